// File: doc/BRIEF.md
# Indexed and Indirect Operand Address Generator

This block forms the effective operand address of one instruction. A short address field taken from the instruction is added to the contents of a selected index register, and the sum wraps within 15 bits. If the instruction asks for indirection, the block reads the control word at that address from memory. It indexes that word with the word's own index field. It keeps walking while each fetched word still asks for indirection, so the chain can be any number of levels deep.

The walk stops on one of two kinds of terminal word. The first kind is a plain indirect word, which yields a full 15-bit operand address. The second kind is a field-select descriptor, which yields a 10-bit base address plus left and right field boundaries. The block loads its index registers through a simple write port and fetches control words over a request/acknowledge read port. It reports the result with a one-cycle done pulse and a count of the extra memory cycles it spent. A depth limit ends a cyclic chain with an error flag.

Word bit numbering runs from 1 to 25. Vector index `k-1` carries word bit `k`.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, `done`, `mem_req`, `busy`, `chain_err`, `fsel`, `op_addr` and `extra_cycles` are all 0.
- R2: If a start is taken with instruction bit 25 equal to 0, `done` rises one clock after the start edge. `op_addr` is then the address field (bits 1-10, zero-extended) plus the index register named by bits 21-24. No memory request is made, `fsel` is 0 and `extra_cycles` is 0.
- R3: Index code 0 adds zero. A code above `NUM_IDX` names an absent register, which reads as 15'h7FFF. Writes to code 0 or to an absent register have no effect.
- R4: Every index addition is taken modulo 2^15, and any carry out of the 15 bits is discarded.
- R5: With instruction bit 25 equal to 1, the block fetches the word at the computed address. While a fetched word has bit 25 equal to 1, the next address is that word's bits 1-10 plus the register named by its bits 21-24, and another fetch follows. `extra_cycles` equals the number of words fetched.
- R6: A fetched word with bit 25 = 0 and bits 18-20 = 000 ends the chain. `op_addr` is its bits 1-15 plus its index register, and `fsel` is 0.
- R7: A fetched word with bit 25 = 0 and bits 18-20 not all zero ends the chain. `op_addr` is its bits 1-10 plus its index register, `fsel` is 1, `fsel_left` is bits 16-20 and `fsel_right` is bits 11-15.
- R8: Once `mem_req` rises, it stays high and `mem_addr` stays unchanged until a cycle in which `mem_ack` is high.
- R9: A start that arrives while `busy` is high is ignored. It produces no result, and the current walk completes unchanged.
- R10: If the `MAX_DEPTH`-th fetched word still requests indirection, the walk ends. `done` is raised with `chain_err` = 1 and `extra_cycles` = `MAX_DEPTH`.
- R11: `done` is high for exactly one cycle per accepted start. The result outputs hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, taken only while idle |
| instr | input | 25 | Instruction word |
| busy | output | 1 | Chain walk in progress |
| mem_req | output | 1 | Control-word read request |
| mem_addr | output | 15 | Read address |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid in this cycle |
| mem_rdata | input | 25 | Fetched control word |
| idx_we | input | 1 | Index register write enable |
| idx_wsel | input | 4 | Index register code to write |
| idx_wdata | input | 15 | Index register write data |
| done | output | 1 | Result pulse |
| op_addr | output | 15 | Final operand address |
| fsel | output | 1 | Result is a field-select descriptor |
| fsel_left | output | 5 | Left field boundary |
| fsel_right | output | 5 | Right field boundary |
| extra_cycles | output | CNT_W (7) | Number of control words fetched |
| chain_err | output | 1 | Depth limit reached |

## Verification
The assertions assume that `mem_ack` is raised only while `mem_req` is high. They also assume that `mem_rdata` is valid in the acknowledge cycle, and that index registers are not rewritten while a walk is in progress.

The bench's memory responder acknowledges only a pending request, and it uses a per-test latency of zero to two cycles. Index writes are issued only while the block is idle. Stray starts are driven only to probe that they are ignored.

// File: rtl/aig_pkg.sv
package aig_pkg;
  localparam int WORD_W = 25;
  localparam int ADDR_W = 15;
  localparam int M_W    = 10;
  localparam int SEL_W  = 4;
  localparam int BND_W  = 5;

  typedef enum logic [1:0] {
    CW_CHAIN = 2'd0,
    CW_PLAIN = 2'd1,
    CW_FSEL  = 2'd2
  } cw_kind_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } walk_st_e;
endpackage

// File: rtl/aig_idx_file.sv
module aig_idx_file
  import aig_pkg::*;
#(
  parameter int NUM_IDX = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rsel,
  output logic [ADDR_W-1:0] rdata
);
  localparam int SLOTS = 1 << SEL_W;

  logic [ADDR_W-1:0] slot [SLOTS];

  assign slot[0] = '0;

  for (genvar i = 1; i < SLOTS; i++) begin : g_slot
    if (i <= NUM_IDX) begin : g_real
      logic [ADDR_W-1:0] q;
      logic              en;
      assign en = we && (wsel == SEL_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= wdata;
      end
      assign slot[i] = q;
    end else begin : g_absent
      assign slot[i] = '1;
    end
  end

  assign rdata = slot[rsel];
endmodule

// File: rtl/aig_word_decode.sv
module aig_word_decode
  import aig_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              is_instr,
  output logic [ADDR_W-1:0] base,
  output logic [SEL_W-1:0]  sel,
  output cw_kind_e          kind,
  output logic [BND_W-1:0]  left_b,
  output logic [BND_W-1:0]  right_b
);
  logic ind_bit;
  logic code_nz;

  assign ind_bit = word[24];
  assign code_nz = |word[19:17];
  assign sel     = word[23:20];
  assign left_b  = word[19:15];
  assign right_b = word[14:10];

  always_comb begin
    if (ind_bit)      kind = CW_CHAIN;
    else if (code_nz) kind = CW_FSEL;
    else              kind = CW_PLAIN;
  end

  always_comb begin
    if (is_instr || ind_bit || code_nz) base = {{(ADDR_W-M_W){1'b0}}, word[M_W-1:0]};
    else                                base = word[ADDR_W-1:0];
  end
endmodule

// File: rtl/aig_addr_add.sv
module aig_addr_add
  import aig_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] idx,
  output logic [ADDR_W-1:0] sum
);
  logic [ADDR_W:0] full;
  assign full = {1'b0, base} + {1'b0, idx};
  assign sum  = full[ADDR_W-1:0];
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import aig_pkg::*;
#(
  parameter int NUM_IDX   = 9,
  parameter int MAX_DEPTH = 64,
  parameter int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [24:0]       instr,
  output logic              busy,
  output logic              mem_req,
  output logic [14:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [24:0]       mem_rdata,
  input  logic              idx_we,
  input  logic [3:0]        idx_wsel,
  input  logic [14:0]       idx_wdata,
  output logic              done,
  output logic [14:0]       op_addr,
  output logic              fsel,
  output logic [4:0]        fsel_left,
  output logic [4:0]        fsel_right,
  output logic [CNT_W-1:0]  extra_cycles,
  output logic              chain_err
);
  localparam logic [CNT_W-1:0] DEPTH_LIM = CNT_W'(MAX_DEPTH);

  walk_st_e          st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_inc;
  logic              done_n;
  logic              load_res;
  logic [ADDR_W-1:0] res_addr_n;
  logic              res_fsel_n, res_err_n;
  logic [BND_W-1:0]  res_l_n, res_r_n;
  logic [CNT_W-1:0]  res_cnt_n;

  logic [WORD_W-1:0] src_word;
  logic [ADDR_W-1:0] dec_base, idx_val, sum;
  logic [SEL_W-1:0]  dec_sel;
  cw_kind_e          dec_kind;
  logic [BND_W-1:0]  dec_l, dec_r;
  logic              in_idle;

  assign in_idle  = (st_q == ST_IDLE);
  assign src_word = in_idle ? instr : mem_rdata;

  aig_word_decode u_dec (
    .word     (src_word),
    .is_instr (in_idle),
    .base     (dec_base),
    .sel      (dec_sel),
    .kind     (dec_kind),
    .left_b   (dec_l),
    .right_b  (dec_r)
  );

  aig_idx_file #(.NUM_IDX(NUM_IDX)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (idx_we),
    .wsel  (idx_wsel),
    .wdata (idx_wdata),
    .rsel  (dec_sel),
    .rdata (idx_val)
  );

  aig_addr_add u_add (
    .base (dec_base),
    .idx  (idx_val),
    .sum  (sum)
  );

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    st_n       = st_q;
    addr_n     = addr_q;
    cnt_n      = cnt_q;
    done_n     = 1'b0;
    res_addr_n = sum;
    res_fsel_n = 1'b0;
    res_err_n  = 1'b0;
    res_l_n    = '0;
    res_r_n    = '0;
    res_cnt_n  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (src_word[24]) begin
            st_n   = ST_FETCH;
            addr_n = sum;
            cnt_n  = '0;
          end else begin
            done_n = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          res_cnt_n = cnt_inc;
          unique case (dec_kind)
            CW_CHAIN: begin
              if (cnt_inc == DEPTH_LIM) begin
                done_n    = 1'b1;
                res_err_n = 1'b1;
                st_n      = ST_IDLE;
              end else begin
                addr_n = sum;
                cnt_n  = cnt_inc;
              end
            end
            CW_FSEL: begin
              done_n     = 1'b1;
              res_fsel_n = 1'b1;
              res_l_n    = dec_l;
              res_r_n    = dec_r;
              st_n       = ST_IDLE;
            end
            default: begin
              done_n = 1'b1;
              st_n   = ST_IDLE;
            end
          endcase
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign load_res = done_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_n;
      addr_q <= addr_n;
      cnt_q  <= cnt_n;
      done   <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr      <= '0;
      fsel         <= 1'b0;
      fsel_left    <= '0;
      fsel_right   <= '0;
      extra_cycles <= '0;
      chain_err    <= 1'b0;
    end else if (load_res) begin
      op_addr      <= res_addr_n;
      fsel         <= res_fsel_n;
      fsel_left    <= res_l_n;
      fsel_right   <= res_r_n;
      extra_cycles <= res_cnt_n;
      chain_err    <= res_err_n;
    end
  end

  assign busy     = (st_q == ST_FETCH);
  assign mem_req  = busy;
  assign mem_addr = addr_q;
endmodule

// File: rtl/aig_chk.sv
module aig_chk #(
  parameter int MAX_DEPTH = 64,
  parameter int CNT_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             mem_req,
  input logic [14:0]      mem_addr,
  input logic             mem_ack,
  input logic             done,
  input logic             fsel,
  input logic [CNT_W-1:0] extra_cycles,
  input logic             chain_err
);
  // R8: request and address held until acknowledge
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: a direct start from idle finishes on the next cycle without a fetch
  a_r2_direct_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !mem_req) |=> (done || mem_req));

  // R10: an error result always reports the full depth
  a_r10_err_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chain_err) |-> (extra_cycles == CNT_W'(MAX_DEPTH) && !fsel));

  // R5: the fetch count never exceeds the depth limit
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (extra_cycles <= CNT_W'(MAX_DEPTH)));

  // R9: done never rises while a walk is still busy
  a_r9_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind eff_addr_gen aig_chk #(.MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_ack      (mem_ack),
  .done         (done),
  .fsel         (fsel),
  .extra_cycles (extra_cycles),
  .chain_err    (chain_err)
);

// File: tb/eff_addr_gen_bench.sv
module eff_addr_gen_bench;
  localparam int NIDX  = 9;
  localparam int MAXD  = 64;
  localparam int CW    = $clog2(MAXD + 1);

  typedef struct {
    logic [14:0]   addr;
    logic          fs;
    logic [4:0]    l;
    logic [4:0]    r;
    logic [CW-1:0] cnt;
    logic          err;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [24:0] instr = '0;
  logic busy, mem_req, mem_ack = 1'b0;
  logic [14:0] mem_addr;
  logic [24:0] mem_rdata = '0;
  logic idx_we = 1'b0;
  logic [3:0] idx_wsel = '0;
  logic [14:0] idx_wdata = '0;
  logic done, fsel, chain_err;
  logic [14:0] op_addr;
  logic [4:0] fsel_left, fsel_right;
  logic [CW-1:0] extra_cycles;

  always #2.5 clk = ~clk;

  eff_addr_gen #(.NUM_IDX(NIDX), .MAX_DEPTH(MAXD)) u_eff_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .idx_we(idx_we), .idx_wsel(idx_wsel),
    .idx_wdata(idx_wdata), .done(done), .op_addr(op_addr), .fsel(fsel),
    .fsel_left(fsel_left), .fsel_right(fsel_right),
    .extra_cycles(extra_cycles), .chain_err(chain_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_done = 0;
  int n_push = 0;
  exp_t sb[$];
  logic [24:0] mem [int];
  logic [14:0] bidx [16];
  int lat = 0;
  int wcnt = 0;
  logic [14:0] held;
  logic prev_done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] mk_ind(input logic [3:0] s, input logic [9:0] m);
    return {1'b1, s, 10'b0, m};
  endfunction
  function automatic logic [24:0] mk_dir(input logic [3:0] s, input logic [9:0] m);
    return {1'b0, s, 10'b0, m};
  endfunction
  function automatic logic [24:0] mk_plain(input logic [3:0] s, input logic [14:0] a);
    return {1'b0, s, 5'b0, a};
  endfunction
  function automatic logic [24:0] mk_fsel(input logic [3:0] s, input logic [4:0] l,
                                          input logic [4:0] r, input logic [9:0] m);
    return {1'b0, s, l, r, m};
  endfunction

  function automatic logic [14:0] add15(input logic [14:0] b, input logic [3:0] s);
    logic [15:0] t;
    t = {1'b0, b} + {1'b0, bidx[s]};
    return t[14:0];
  endfunction

  function automatic exp_t model(input logic [24:0] ins);
    exp_t e;
    logic [14:0] a;
    logic [24:0] w;
    int c;
    e = '{addr: '0, fs: 1'b0, l: '0, r: '0, cnt: '0, err: 1'b0};
    a = add15({5'b0, ins[9:0]}, ins[23:20]);
    if (!ins[24]) begin e.addr = a; return e; end
    c = 0;
    forever begin
      w = mem.exists(int'(a)) ? mem[int'(a)] : 25'b0;
      c++;
      if (w[24]) begin
        a = add15({5'b0, w[9:0]}, w[23:20]);
        if (c == MAXD) begin e.addr = a; e.err = 1'b1; e.cnt = CW'(c); return e; end
      end else if (w[19:17] == 3'b000) begin
        e.addr = add15(w[14:0], w[23:20]); e.cnt = CW'(c); return e;
      end else begin
        e.addr = add15({5'b0, w[9:0]}, w[23:20]); e.fs = 1'b1;
        e.l = w[19:15]; e.r = w[14:10]; e.cnt = CW'(c); return e;
      end
    end
  endfunction

  task automatic wr_idx(input logic [3:0] s, input logic [14:0] v);
    @(negedge clk);
    idx_we = 1'b1; idx_wsel = s; idx_wdata = v;
    if (s != 4'd0 && int'(s) <= NIDX) bidx[s] = v;
    @(negedge clk);
    idx_we = 1'b0;
  endtask

  task automatic issue(input logic [24:0] ins);
    @(negedge clk);
    while (busy) @(negedge clk);
    sb.push_back(model(ins));
    n_push++;
    instr = ins; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // memory responder with latency and R8 address hold check
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt > 0) chk(mem_addr == held, "R8 address hold", mem_addr, held);
      held = mem_addr;
      if (wcnt >= lat) begin
        mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 25'b0;
        mem_ack = 1'b1;
      end else wcnt++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        exp_t e;
        n_done++;
        chk(!prev_done, "R11 single pulse", prev_done, 0);
        if (sb.size() == 0) begin
          chk(1'b0, "R9 unexpected result", n_done, n_push);
        end else begin
          e = sb.pop_front();
          chk(chain_err == e.err, "R10 error flag", chain_err, e.err);
          chk(extra_cycles == e.cnt, "R5 fetch count", extra_cycles, e.cnt);
          if (!e.err) begin
            chk(op_addr == e.addr, "R2/R5/R6/R7 address", op_addr, e.addr);
            chk(fsel == e.fs, "R6/R7 fsel", fsel, e.fs);
            if (e.fs) begin
              chk(fsel_left == e.l, "R7 left", fsel_left, e.l);
              chk(fsel_right == e.r, "R7 right", fsel_right, e.r);
            end
          end
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) bidx[i] = (i == 0) ? 15'h0 : ((i <= NIDX) ? 15'h0 : 15'h7FFF);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !mem_req && !busy && !chain_err && !fsel, "R1 reset flags",
        {done, mem_req, busy, chain_err, fsel}, 0);
    chk(op_addr == 0 && extra_cycles == 0, "R1 reset values", op_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req && !busy, "R1 after release", {done, mem_req, busy}, 0);

    wr_idx(4'd1, 15'h0005);
    wr_idx(4'd2, 15'h7FF0);
    wr_idx(4'd9, 15'h0100);
    wr_idx(4'd12, 15'h0003);   // R3 absent register, write ignored
    wr_idx(4'd0, 15'h0009);    // R3 code 0, write ignored

    // R2 timing: done one cycle after the start edge, no request
    @(negedge clk);
    sb.push_back(model(mk_dir(4'd0, 10'h123))); n_push++;
    instr = mk_dir(4'd0, 10'h123); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R2 done timing", done, 1);
    chk(mem_req == 1'b0, "R2 no request", mem_req, 0);
    chk(op_addr == 15'h123, "R3 code 0 no indexing", op_addr, 15'h123);
    wait_idle();

    issue(mk_dir(4'd1, 10'h200));          // R2 -> 0x205
    issue(mk_dir(4'd2, 10'h3FF));          // R4 wrap -> 0x03EF
    wait_idle();
    chk(op_addr == 15'h03EF, "R4 wraparound", op_addr, 15'h03EF);
    issue(mk_dir(4'd12, 10'h010));         // R3 all ones -> 0x000F
    wait_idle();
    chk(op_addr == 15'h000F, "R3 absent register", op_addr, 15'h000F);
    issue(mk_dir(4'd0, 10'h001));
    wait_idle();
    chk(op_addr == 15'h0001, "R3 code 0 write ignored", op_addr, 15'h0001);

    // R5/R6 one level, plain terminal
    mem[32'h40] = mk_plain(4'd1, 15'h1234);
    lat = 1;
    issue(mk_ind(4'd0, 10'h040));
    wait_idle();
    chk(op_addr == 15'h1239, "R6 plain terminal", op_addr, 15'h1239);

    // R7 one level, field-select terminal
    mem[32'h41] = mk_fsel(4'd9, 5'b10110, 5'b01001, 10'h02A);
    issue(mk_ind(4'd0, 10'h041));
    wait_idle();
    chk(fsel && op_addr == 15'h012A, "R7 descriptor", op_addr, 15'h012A);

    // R5/R7/R4 three levels ending on a descriptor, slow memory
    mem[32'h55]  = mk_ind(4'd0, 10'h060);
    mem[32'h60]  = mk_ind(4'd9, 10'h010);
    mem[32'h110] = mk_fsel(4'd2, 5'b00101, 5'b00011, 10'h3FF);
    lat = 2;
    issue(mk_ind(4'd1, 10'h050));
    wait_idle();
    chk(extra_cycles == 3, "R5 three levels", extra_cycles, 3);

    // R5/R6 three levels ending plain, zero latency
    mem[32'h300] = mk_ind(4'd1, 10'h100);
    mem[32'h105] = mk_ind(4'd12, 10'h002);
    mem[32'h1]   = mk_plain(4'd2, 15'h0020);
    lat = 0;
    issue(mk_ind(4'd0, 10'h300));
    wait_idle();

    // R9 start while busy is ignored
    lat = 2;
    issue(mk_ind(4'd0, 10'h040));
    instr = mk_dir(4'd0, 10'h077); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk(op_addr == 15'h1239, "R9 busy start ignored", op_addr, 15'h1239);

    // R10 cyclic chain hits the depth limit
    mem[32'h200] = mk_ind(4'd0, 10'h200);
    lat = 0;
    issue(mk_ind(4'd0, 10'h200));
    wait_idle();
    chk(chain_err == 1'b1, "R10 cyclic chain", chain_err, 1);

    repeat (4) @(negedge clk);
    chk(n_done == n_push, "R11 one done per start", n_done, n_push);
    chk(sb.size() == 0, "R11 scoreboard drained", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule